// File: doc/BRIEF.md
# Power-On Reset Release Sequencer

This block brings a device out of cold reset in a fixed order once the global power-on reset has been released. It drives active-low resets for the warm-reset output, the clock synthesizers, the main processor and a set of further subdomains. Each stage opens only after the stage before it. The main processor waits for its clock to run. The other domains wait for the processor to report that its own reset has completed, and each of them also waits for its own clock-running flag.

The global reset input is active low. Asserting it clears every output at once, without waiting for a clock edge. Release is synchronized internally. The clock-running flags and the processor's done flag are treated as asynchronous and pass through synchronizers. A group of software-controlled resets is released together with the subdomain stage, and each follows a default bit: a bit set to 1 keeps that reset asserted, and a bit at 0 lets it go.

Top module: `por_release_seq`

## Requirements
- R1: While `por_rst_n` is low, every reset output is 0. A falling edge of `por_rst_n` drives all of them to 0 at once, without waiting for a clock edge.
- R2: After `por_rst_n` rises, internal reset release takes SYNC_STAGES rising edges. `warm_out_rst_n` goes to 1 on the next edge after that, which is edge SYNC_STAGES+1.
- R3: `pll_rst_n` goes to 1 exactly one clock edge after `warm_out_rst_n` does.
- R4: `mpu_rst_n` goes to 1 only while the synchronized `mpu_clk_ok` is 1, and no sooner than two edges after `pll_rst_n`. A flag passes the synchronizer in SYNC_STAGES edges, and holding `mpu_clk_ok` low holds the processor in reset.
- R5: No subdomain reset is released before the processor reset is. A high `mpu_rst_done` is acted on only after `mpu_rst_n` is 1. The subdomain stage begins one edge after the synchronized done flag is seen in that state.
- R6: During the subdomain stage, `dom_rst_n[i]` goes to 1 on the first edge at which the synchronized `dom_clk_ok[i]` is 1. Each domain is released on its own. Once released, a domain stays released until the next power-on reset, even if its clock flag drops.
- R7: Each `sw_rst_n[j]` is 0 before the subdomain stage. From that stage on, it equals the inverse of `sw_rst_dflt[j]`: 1 keeps the reset asserted and 0 releases it. A change to a default bit appears one edge later.
- R8: Asserting `por_rst_n` at any point in the sequence restarts it. The next release repeats the whole order from the warm-reset output.
- R9: At every clock edge outside reset, the outputs keep the order. `pll_rst_n` high implies `warm_out_rst_n` high, and `mpu_rst_n` high implies `pll_rst_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| por_rst_n | input | 1 | Global power-on reset, active low, asynchronous |
| mpu_clk_ok | input | 1 | Main processor clock is running (asynchronous) |
| mpu_rst_done | input | 1 | Processor reports its reset has completed (asynchronous) |
| dom_clk_ok | input | N_DOM | Per-subdomain clock-running flags (asynchronous) |
| sw_rst_dflt | input | N_SW | Default bits for software resets, 1 = keep asserted |
| warm_out_rst_n | output | 1 | Warm-reset output, active low |
| pll_rst_n | output | 1 | Clock synthesizer reset, active low |
| mpu_rst_n | output | 1 | Main processor reset, active low |
| dom_rst_n | output | N_DOM | Subdomain resets, active low |
| sw_rst_n | output | N_SW | Software-controlled resets, active low |

## Verification
The warm-reset output is due SYNC_STAGES+1 edges after the power-on reset is released, and the synthesizer reset follows one edge later. A flag change reaches the sequencer SYNC_STAGES edges after it is driven. After that, the processor reset, the start of the subdomain stage and each domain release each take one more edge. The bench reference model shifts every driven flag through a delay line of SYNC_STAGES entries and moves a phase counter on the same edges. All outputs are compared on the falling clock edge, halfway between updates. The directed checks wait long enough for each delay to run out, and the R2 and R3 edge counts are tested on their exact edges.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_WARM      = 3'd1,
      ST_PLL       = 3'd2,
      ST_MPU_WAIT  = 3'd3,
      ST_DONE_WAIT = 3'd4,
      ST_DOMAINS   = 3'd5,
      ST_FINISHED  = 3'd6
   } seq_state_t;

endpackage

// File: rtl/por_seq_rst_sync.sv
module por_seq_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n_sync
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign rst_n_sync = chain[STAGES-1];
endmodule

// File: rtl/por_seq_sync.sv
module por_seq_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/por_seq_dom_gate.sv
module por_seq_dom_gate #(
   parameter int N_DOM = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stage_en,
   input  logic [N_DOM-1:0] clk_ok_s,
   output logic [N_DOM-1:0] rel_q,
   output logic             all_rel_nxt
);
   for (genvar i = 0; i < N_DOM; i++) begin : g_dom
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        rel_q[i] <= 1'b0;
         else if (stage_en && clk_ok_s[i])  rel_q[i] <= 1'b1;
      end
   end

   assign all_rel_nxt = &(rel_q | clk_ok_s);
endmodule

// File: rtl/por_seq_fsm.sv
module por_seq_fsm
   import por_seq_pkg::*;
#(
   parameter int N_SW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mpu_ok_s,
   input  logic            done_s,
   input  logic            dom_all_nxt,
   input  logic [N_SW-1:0] sw_dflt,
   output logic            warm_q,
   output logic            pll_q,
   output logic            mpu_q,
   output logic            dom_stage,
   output logic [N_SW-1:0] sw_q
);
   seq_state_t st, nxt;

   always_comb begin
      nxt = st;
      unique case (st)
         ST_IDLE:      nxt = ST_WARM;
         ST_WARM:      nxt = ST_PLL;
         ST_PLL:       nxt = ST_MPU_WAIT;
         ST_MPU_WAIT:  if (mpu_ok_s)    nxt = ST_DONE_WAIT;
         ST_DONE_WAIT: if (done_s)      nxt = ST_DOMAINS;
         ST_DOMAINS:   if (dom_all_nxt) nxt = ST_FINISHED;
         ST_FINISHED:  nxt = ST_FINISHED;
         default:      nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         warm_q <= 1'b0;
         pll_q  <= 1'b0;
         mpu_q  <= 1'b0;
         sw_q   <= '0;
      end else begin
         st     <= nxt;
         warm_q <= (nxt != ST_IDLE);
         pll_q  <= (nxt >= ST_PLL);
         mpu_q  <= (nxt >= ST_DONE_WAIT);
         sw_q   <= (nxt >= ST_DOMAINS) ? ~sw_dflt : '0;
      end
   end

   assign dom_stage = (st == ST_DOMAINS);
endmodule

// File: rtl/por_release_seq.sv
module por_release_seq #(
   parameter int N_DOM       = 4,
   parameter int N_SW        = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             por_rst_n,
   input  logic             mpu_clk_ok,
   input  logic             mpu_rst_done,
   input  logic [N_DOM-1:0] dom_clk_ok,
   input  logic [N_SW-1:0]  sw_rst_dflt,
   output logic             warm_out_rst_n,
   output logic             pll_rst_n,
   output logic             mpu_rst_n,
   output logic [N_DOM-1:0] dom_rst_n,
   output logic [N_SW-1:0]  sw_rst_n
);
   localparam int FW = N_DOM + 2;

   if (N_DOM < 1)       begin : g_bad_dom  $error("N_DOM must be at least 1");       end
   if (N_SW < 1)        begin : g_bad_sw   $error("N_SW must be at least 1");        end
   if (SYNC_STAGES < 2) begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end

   logic          rst_int_n;
   logic [FW-1:0] flags_s;
   logic [N_DOM-1:0] dom_ok_s;
   logic          mpu_ok_s;
   logic          done_s;
   logic          dom_stage;
   logic          dom_all_nxt;

   por_seq_rst_sync #(.STAGES(SYNC_STAGES)) u_rsync (
      .clk        (clk),
      .arst_n     (por_rst_n),
      .rst_n_sync (rst_int_n)
   );

   por_seq_sync #(.W(FW), .STAGES(SYNC_STAGES)) u_fsync (
      .clk   (clk),
      .rst_n (rst_int_n),
      .d     ({mpu_rst_done, mpu_clk_ok, dom_clk_ok}),
      .q     (flags_s)
   );

   assign dom_ok_s = flags_s[N_DOM-1:0];
   assign mpu_ok_s = flags_s[N_DOM];
   assign done_s   = flags_s[N_DOM+1];

   por_seq_fsm #(.N_SW(N_SW)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .mpu_ok_s    (mpu_ok_s),
      .done_s      (done_s),
      .dom_all_nxt (dom_all_nxt),
      .sw_dflt     (sw_rst_dflt),
      .warm_q      (warm_out_rst_n),
      .pll_q       (pll_rst_n),
      .mpu_q       (mpu_rst_n),
      .dom_stage   (dom_stage),
      .sw_q        (sw_rst_n)
   );

   por_seq_dom_gate #(.N_DOM(N_DOM)) u_dom (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .stage_en    (dom_stage),
      .clk_ok_s    (dom_ok_s),
      .rel_q       (dom_rst_n),
      .all_rel_nxt (dom_all_nxt)
   );
endmodule

// File: rtl/por_seq_chk.sv
module por_seq_chk #(
   parameter int N_DOM = 4,
   parameter int N_SW  = 2
) (
   input logic             clk,
   input logic             por_rst_n,
   input logic             mpu_ok_s,
   input logic [N_DOM-1:0] dom_ok_s,
   input logic [N_SW-1:0]  sw_rst_dflt,
   input logic             warm_out_rst_n,
   input logic             pll_rst_n,
   input logic             mpu_rst_n,
   input logic [N_DOM-1:0] dom_rst_n,
   input logic [N_SW-1:0]  sw_rst_n
);
   always @(negedge clk) begin
      if (!por_rst_n)
         assert_async_clear_R1: assert (!warm_out_rst_n && !pll_rst_n && !mpu_rst_n
                                        && dom_rst_n == '0 && sw_rst_n == '0);
   end

   assert_warm_before_pll_R9: assert property (@(posedge clk) disable iff (!por_rst_n)
      pll_rst_n |-> warm_out_rst_n);

   assert_pll_before_mpu_R9: assert property (@(posedge clk) disable iff (!por_rst_n)
      mpu_rst_n |-> pll_rst_n);

   assert_mpu_before_dom_R5: assert property (@(posedge clk) disable iff (!por_rst_n)
      (|dom_rst_n) |-> mpu_rst_n);

   assert_mpu_clk_gate_R4: assert property (@(posedge clk) disable iff (!por_rst_n)
      $rose(mpu_rst_n) |-> $past(mpu_ok_s));

   for (genvar i = 0; i < N_DOM; i++) begin : g_dchk
      assert_dom_clk_gate_R6: assert property (@(posedge clk) disable iff (!por_rst_n)
         $rose(dom_rst_n[i]) |-> $past(dom_ok_s[i]));
      assert_dom_sticky_R6: assert property (@(posedge clk) disable iff (!por_rst_n)
         !$fell(dom_rst_n[i]));
   end

   for (genvar j = 0; j < N_SW; j++) begin : g_schk
      assert_sw_default_R7: assert property (@(posedge clk) disable iff (!por_rst_n)
         sw_rst_n[j] |-> !$past(sw_rst_dflt[j]));
   end
endmodule

bind por_release_seq por_seq_chk #(.N_DOM(N_DOM), .N_SW(N_SW)) u_chk (
   .clk            (clk),
   .por_rst_n      (por_rst_n),
   .mpu_ok_s       (mpu_ok_s),
   .dom_ok_s       (dom_ok_s),
   .sw_rst_dflt    (sw_rst_dflt),
   .warm_out_rst_n (warm_out_rst_n),
   .pll_rst_n      (pll_rst_n),
   .mpu_rst_n      (mpu_rst_n),
   .dom_rst_n      (dom_rst_n),
   .sw_rst_n       (sw_rst_n)
);

// File: tb/tb_por_release_seq.sv
`timescale 1ns/1ps
module tb_por_release_seq;
   localparam int N_DOM = 4;
   localparam int N_SW  = 2;
   localparam int SYNC  = 2;
   localparam int FW    = N_DOM + 2;

   logic clk = 1'b0;
   logic por_rst_n;
   logic mpu_clk_ok, mpu_rst_done;
   logic [N_DOM-1:0] dom_clk_ok;
   logic [N_SW-1:0]  sw_rst_dflt;
   logic warm_out_rst_n, pll_rst_n, mpu_rst_n;
   logic [N_DOM-1:0] dom_rst_n;
   logic [N_SW-1:0]  sw_rst_n;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   por_release_seq #(.N_DOM(N_DOM), .N_SW(N_SW), .SYNC_STAGES(SYNC)) dut (.*);

   // behavioural reference: edge counter, flag delay line, phase number
   int rc;
   int ph;
   logic [FW-1:0] fp [SYNC];
   logic [N_DOM-1:0] m_dom;
   logic [N_SW-1:0]  m_sw;

   always @(posedge clk or negedge por_rst_n) begin
      if (!por_rst_n) begin
         rc = 0; ph = 0; m_dom = '0; m_sw = '0;
         for (int k = 0; k < SYNC; k++) fp[k] = '0;
      end else begin
         logic [FW-1:0] fs;
         bit live;
         fs   = fp[SYNC-1];
         live = (rc >= SYNC);
         if (rc < SYNC) rc++;
         if (live) begin
            for (int k = SYNC-1; k > 0; k--) fp[k] = fp[k-1];
            fp[0] = {mpu_rst_done, mpu_clk_ok, dom_clk_ok};
            case (ph)
               0: ph = 1;
               1: ph = 2;
               2: ph = 3;
               3: if (fs[N_DOM])   ph = 4;
               4: if (fs[N_DOM+1]) ph = 5;
               5: begin
                  m_dom = m_dom | fs[N_DOM-1:0];
                  if (&m_dom) ph = 6;
               end
               default: ph = ph;
            endcase
            m_sw = (ph >= 5) ? ~sw_rst_dflt : '0;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!finished) begin
         chk("R2 warm_out_rst_n", 32'(warm_out_rst_n), 32'(ph >= 1));
         chk("R3 pll_rst_n",      32'(pll_rst_n),      32'(ph >= 2));
         chk("R4 mpu_rst_n",      32'(mpu_rst_n),      32'(ph >= 4));
         chk("R6 dom_rst_n",      32'(dom_rst_n),      32'(m_dom));
         chk("R7 sw_rst_n",       32'(sw_rst_n),       32'(m_sw));
      end
   end

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #200000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
   end

   initial begin
      por_rst_n = 1'b0; mpu_clk_ok = 1'b1; mpu_rst_done = 1'b0;
      dom_clk_ok = 4'b0101; sw_rst_dflt = 2'b01;
      edges(3);
      // R1: reset state
      chk("R1 all outputs in reset", 32'({warm_out_rst_n, pll_rst_n, mpu_rst_n, dom_rst_n, sw_rst_n}), 32'h0);

      por_rst_n = 1'b1;
      edges(SYNC);
      chk("R2 warm not yet", 32'(warm_out_rst_n), 32'h0);
      edges(1);
      chk("R2 warm released", 32'(warm_out_rst_n), 32'h1);
      chk("R3 pll not yet", 32'(pll_rst_n), 32'h0);
      edges(1);
      chk("R3 pll released", 32'(pll_rst_n), 32'h1);
      chk("R9 mpu after pll", 32'(mpu_rst_n), 32'h0);

      edges(20);
      chk("R4 mpu released with clock", 32'(mpu_rst_n), 32'h1);
      chk("R5 domains held without done", 32'(dom_rst_n), 32'h0);

      mpu_rst_done = 1'b1;
      edges(10);
      chk("R6 running domains released", 32'(dom_rst_n), 32'h5);
      chk("R7 sw follows default", 32'(sw_rst_n), 32'h2);

      dom_clk_ok = 4'b1111;
      edges(10);
      chk("R6 late domains released", 32'(dom_rst_n), 32'hf);

      dom_clk_ok = 4'b0000;
      edges(6);
      chk("R6 release is sticky", 32'(dom_rst_n), 32'hf);

      sw_rst_dflt = 2'b10;
      edges(1);
      chk("R7 default change next edge", 32'(sw_rst_n), 32'h1);

      // R8: reset mid-run, then restart with processor clock stopped
      por_rst_n = 1'b0;
      #0.5;
      chk("R1 async clear", 32'({warm_out_rst_n, pll_rst_n, mpu_rst_n, dom_rst_n, sw_rst_n}), 32'h0);
      mpu_clk_ok = 1'b0; mpu_rst_done = 1'b1; dom_clk_ok = 4'b1111;
      edges(3);
      por_rst_n = 1'b1;
      edges(30);
      chk("R4 mpu held without clock", 32'(mpu_rst_n), 32'h0);
      chk("R5 early done ignored", 32'(dom_rst_n), 32'h0);
      chk("R8 restart reached pll", 32'(pll_rst_n), 32'h1);

      mpu_clk_ok = 1'b1;
      edges(SYNC + 1);
      chk("R4 mpu released after sync", 32'(mpu_rst_n), 32'h1);
      chk("R5 domains wait one edge", 32'(dom_rst_n), 32'h0);
      edges(2);
      chk("R8 full sequence repeated", 32'(dom_rst_n), 32'hf);
      chk("R7 sw after restart", 32'(sw_rst_n), 32'h1);

      // reset during the processor wait
      por_rst_n = 1'b0;
      edges(2);
      mpu_clk_ok = 1'b0;
      por_rst_n = 1'b1;
      edges(8);
      por_rst_n = 1'b0;
      edges(1);
      chk("R8 reset mid wait", 32'({warm_out_rst_n, pll_rst_n, mpu_rst_n}), 32'h0);
      por_rst_n = 1'b1;
      mpu_clk_ok = 1'b1;
      edges(15);
      chk("R8 second restart complete", 32'(dom_rst_n), 32'hf);

      summary();
   end
endmodule